// File: doc/BRIEF.md
# Transaction Completion Status Counter Bank

This block keeps the completion counters that firmware polls to build barriers on the network command path. The command path reports two kinds of events. An issue event says that a read, write or atomic request has left the tile, and for writes whether it is posted or non-posted. A completion event says that a response or acknowledgement has come back, together with the transaction ID and the number of destinations that acknowledged. A single completion event can therefore move the acknowledgement counter by a whole multicast fan-out. Each event class bumps fixed counters at fixed slot indices. The block also tracks the number of outstanding requests for each transaction ID.

Software sees a read-only window of 128 word slots. The slots that are not implemented read as zero. Firmware records a counter, issues traffic, and spins until the counter reaches its own expected total. Counters only move forward, modulo their width. The outstanding counts per ID are the exception: a single register write zeroes the IDs selected by a bit mask, so a lost response cannot leave an ID stuck.

Top module: `txn_status_counters`

## Requirements
- R1: After reset every counter slot reads 0, including slots that held non-zero values before the reset.
- R2: Slot n of the window is read at byte address 0x200 + 4*n (n = 0..127), and `rd_data` returns it one cycle after `rd_addr` is presented, showing the value before that cycle's updates. Unimplemented slots, unaligned addresses and addresses outside 0x200..0x3FF read 0.
- R3: Issue accounting (kind code 0 = read, 1 = write, 2 = atomic). Every issue event increments slot 4. A read also increments slot 5. A write increments slot 10 when `issue_nonposted` is 1 and slot 11 when it is 0.
- R4: Completion accounting. An atomic completion increments slot 0 and a read completion increments slot 2. A write completion adds `cmpl_ack_count` to slot 1, so a multicast adds its destination count in one event, and a count of 0 adds nothing.
- R5: Slot 16 + ID holds the outstanding count for that ID. It rises by 1 on an issued read, atomic or non-posted write, and falls by 1 on any completion with that ID, never going below 0. An increment and a decrement for the same ID in the same cycle leave it unchanged.
- R6: A write to address 0x60 zeroes the outstanding count of every ID i for which `wr_data[i]` is 1 and leaves the others alone. An issue or completion for a cleared ID in the same cycle is applied on top of the zero.
- R7: All counters wrap modulo 2^CNT_W (32 by default). An issue event and a completion event in the same cycle are both counted.
- R8: Bus writes to any address other than 0x60, including the counter window, change nothing. Events with kind code 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An issue event is present this cycle |
| issue_kind | input | 2 | Issue class: 0 read, 1 write, 2 atomic, 3 none |
| issue_nonposted | input | 1 | For writes: 1 = acknowledgement expected |
| issue_tid | input | TID_W (4) | Transaction ID of the issued request |
| cmpl_valid | input | 1 | A completion event is present this cycle |
| cmpl_kind | input | 2 | Completion class, same coding as `issue_kind` |
| cmpl_tid | input | TID_W (4) | Transaction ID of the completed request |
| cmpl_ack_count | input | DEST_W (8) | Number of destinations acknowledging a write |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (16) | Register write byte address |
| wr_data | input | DATA_W (32) | Register write data; bits [NUM_ID-1:0] form the clear mask |
| rd_addr | input | ADDR_W (16) | Register read byte address, sampled every cycle |
| rd_data | output | DATA_W (32) | Read data for the previous cycle's `rd_addr` |

## Verification
The hardest situation to reach from the ports is counter wrap. At 32 bits it takes billions of events, so the bench builds the block with a 10-bit counter width and drives write completions with the largest destination count until slot 1 rolls over. Next hardest is one ID receiving a mask clear, an issue and a completion in the same cycle. Directed cycles stack these events on purpose, and a long random phase then mixes all of them. A behavioural slot model predicts `rd_data` on every cycle.

// File: rtl/txn_stat_pkg.sv
// Package: shared types and constants for the completion status counter bank.
// Assumes the counter window is aligned to its own size (0x200 bytes).
package txn_stat_pkg;

    // Event class carried on both the issue and the completion channel
    typedef enum logic [1:0] {
        KIND_READ   = 2'd0,
        KIND_WRITE  = 2'd1,
        KIND_ATOMIC = 2'd2,
        KIND_NONE   = 2'd3
    } txn_kind_e;

    // Positions of the fixed counters inside the packed fixed-counter array
    localparam int NUM_FIXED      = 7;
    localparam int FIX_ATOMIC_RSP = 0;
    localparam int FIX_WR_ACK     = 1;
    localparam int FIX_RD_RSP     = 2;
    localparam int FIX_ACCEPTED   = 3;
    localparam int FIX_RD_SENT    = 4;
    localparam int FIX_NP_WR_SENT = 5;
    localparam int FIX_P_WR_SENT  = 6;

    // Window geometry
    localparam int NUM_SLOTS          = 128;
    localparam int CNT_REGION_BASE    = 'h200;
    localparam int CLEAR_REG_OFFSET   = 'h60;
    localparam int OUTST_BASE_INDEX   = 16;

    // Window slot index that software uses for each fixed counter
    function automatic int fixed_slot_index(input int f);
        case (f)
            FIX_ATOMIC_RSP: return 0;
            FIX_WR_ACK:     return 1;
            FIX_RD_RSP:     return 2;
            FIX_ACCEPTED:   return 4;
            FIX_RD_SENT:    return 5;
            FIX_NP_WR_SENT: return 10;
            default:        return 11;
        endcase
    endfunction

endpackage

// File: rtl/stat_event_decode.sv
// Module: stat_event_decode
// Turns one issue event and one completion event per cycle into an increment
// amount for every fixed counter, plus the increment and decrement requests
// for the outstanding bank. Purely combinational.
// Assumes DEST_W <= CNT_W so the destination count fits a counter increment.
module stat_event_decode
    import txn_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DEST_W = 8
) (
    input  logic                             issue_valid,
    input  logic [1:0]                       issue_kind,
    input  logic                             issue_nonposted,
    input  logic                             cmpl_valid,
    input  logic [1:0]                       cmpl_kind,
    input  logic [DEST_W-1:0]                cmpl_ack_count,
    output logic [NUM_FIXED-1:0][CNT_W-1:0]  fixed_inc,
    output logic                             outst_inc,
    output logic                             outst_dec
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    txn_kind_e ikind;
    txn_kind_e ckind;
    logic [CNT_W-1:0] ack_ext;

    assign ikind   = txn_kind_e'(issue_kind);
    assign ckind   = txn_kind_e'(cmpl_kind);
    assign ack_ext = CNT_W'(cmpl_ack_count);

    // Increment amount for each fixed counter from both event channels
    always_comb begin
        fixed_inc = '0;
        if (issue_valid) begin
            case (ikind)
                KIND_READ: begin
                    fixed_inc[FIX_ACCEPTED] = ONE;
                    fixed_inc[FIX_RD_SENT]  = ONE;
                end
                KIND_WRITE: begin
                    fixed_inc[FIX_ACCEPTED] = ONE;
                    if (issue_nonposted) fixed_inc[FIX_NP_WR_SENT] = ONE;
                    else                 fixed_inc[FIX_P_WR_SENT]  = ONE;
                end
                KIND_ATOMIC: fixed_inc[FIX_ACCEPTED] = ONE;
                default: ;
            endcase
        end
        if (cmpl_valid) begin
            case (ckind)
                KIND_ATOMIC: fixed_inc[FIX_ATOMIC_RSP] = ONE;
                KIND_WRITE:  fixed_inc[FIX_WR_ACK]     = ack_ext;
                KIND_READ:   fixed_inc[FIX_RD_RSP]     = ONE;
                default: ;
            endcase
        end
    end

    // Requests that expect a response are tracked as outstanding
    always_comb begin
        outst_inc = 1'b0;
        if (issue_valid) begin
            case (ikind)
                KIND_READ, KIND_ATOMIC: outst_inc = 1'b1;
                KIND_WRITE:             outst_inc = issue_nonposted;
                default:                outst_inc = 1'b0;
            endcase
        end
    end

    // Every valid completion retires one outstanding request of its ID
    assign outst_dec = cmpl_valid && (ckind != KIND_NONE);

endmodule

// File: rtl/stat_accum.sv
// Module: stat_accum
// One monotonically increasing counter that adds a per-cycle amount and
// wraps modulo 2^CNT_W. Assumes the amount is already zero when idle.
module stat_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] inc,
    output logic [CNT_W-1:0] q
);

    // Accumulate the increment, clearing on synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q + inc;
    end

endmodule

// File: rtl/stat_outstanding_bank.sv
// Module: stat_outstanding_bank
// Per-transaction-ID outstanding request counters. Each cycle the mask clear
// is applied first, then at most one increment and one decrement. Equal
// increment and decrement cancel, and a decrement never goes below zero.
// Assumes NUM_ID is a power of two, so every TID value addresses an ID.
module stat_outstanding_bank #(
    parameter int CNT_W  = 32,
    parameter int NUM_ID = 16,
    parameter int TID_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc_valid,
    input  logic [TID_W-1:0]              inc_tid,
    input  logic                          dec_valid,
    input  logic [TID_W-1:0]              dec_tid,
    input  logic                          clr_valid,
    input  logic [NUM_ID-1:0]             clr_mask,
    output logic [NUM_ID-1:0][CNT_W-1:0]  q
);

    for (genvar i = 0; i < NUM_ID; i++) begin : g_id
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] nxt;

        assign up   = inc_valid && (inc_tid == TID_W'(i));
        assign dn   = dec_valid && (dec_tid == TID_W'(i));
        assign base = (clr_valid && clr_mask[i]) ? '0 : q[i];

        // Next count: clear first, then the net of increment and decrement
        always_comb begin
            nxt = base;
            if (up && !dn)                   nxt = base + CNT_W'(1);
            else if (dn && !up && base != 0) nxt = base - CNT_W'(1);
        end

        // Register the outstanding count of this ID
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= '0;
            else        q[i] <= nxt;
        end
    end

endmodule

// File: rtl/stat_read_port.sv
// Module: stat_read_port
// Registered read of the counter window. It decodes a byte address into a
// slot index and returns the fixed counter, the outstanding count or zero,
// zero-extended to the bus width. Assumes CNT_W <= DATA_W and that the
// window base is a multiple of the window size.
module stat_read_port
    import txn_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int NUM_ID = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_FIXED-1:0][CNT_W-1:0]  fixed_q,
    input  logic [NUM_ID-1:0][CNT_W-1:0]     outst_q,
    output logic [DATA_W-1:0]                rd_data
);

    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int WIN_BYTES = NUM_SLOTS * 4;

    logic              in_window;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  sel;

    assign in_window = (rd_addr >= ADDR_W'(CNT_REGION_BASE)) &&
                       (rd_addr <  ADDR_W'(CNT_REGION_BASE + WIN_BYTES)) &&
                       (rd_addr[1:0] == 2'b00);
    assign slot = rd_addr[SLOT_W+1:2];

    // Select the counter that owns the addressed slot, zero when none does
    always_comb begin
        sel = '0;
        if (in_window) begin
            for (int f = 0; f < NUM_FIXED; f++) begin
                if (slot == SLOT_W'(fixed_slot_index(f))) sel = fixed_q[f];
            end
            for (int i = 0; i < NUM_ID; i++) begin
                if (slot == SLOT_W'(OUTST_BASE_INDEX + i)) sel = outst_q[i];
            end
        end
    end

    // Register the read data for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= DATA_W'(sel);
    end

endmodule

// File: rtl/txn_status_counters.sv
// Module: txn_status_counters (top)
// Completion status counter bank. Issue and completion events from the command
// path update fixed counters and per-ID outstanding counts. A register write
// to the clear offset zeroes the selected outstanding counts, and every slot
// can be read back at 0x200 + 4*index.
// Assumes at most one issue and one completion event per cycle, DEST_W <= CNT_W
// <= DATA_W, NUM_ID a power of two and OUTST_BASE_INDEX + NUM_ID <= 128.
module txn_status_counters
    import txn_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DEST_W = 8,
    parameter int NUM_ID = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int TID_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [1:0]         issue_kind,
    input  logic               issue_nonposted,
    input  logic [TID_W-1:0]   issue_tid,
    input  logic               cmpl_valid,
    input  logic [1:0]         cmpl_kind,
    input  logic [TID_W-1:0]   cmpl_tid,
    input  logic [DEST_W-1:0]  cmpl_ack_count,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);

    logic [NUM_FIXED-1:0][CNT_W-1:0] fixed_inc;
    logic [NUM_FIXED-1:0][CNT_W-1:0] fixed_q;
    logic [NUM_ID-1:0][CNT_W-1:0]    outst_q;
    logic                            outst_inc;
    logic                            outst_dec;
    logic                            clr_hit;
    logic [NUM_ID-1:0]               clr_mask;
    logic                            unused_wr_hi;

    // Only the clear register is writable; everything else is read-only
    assign clr_hit  = wr_en && (wr_addr == ADDR_W'(CLEAR_REG_OFFSET));
    assign clr_mask = wr_data[NUM_ID-1:0];
    if (DATA_W > NUM_ID) begin : g_hi
        assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_ID];
    end else begin : g_nohi
        assign unused_wr_hi = 1'b0;
    end

    stat_event_decode #(.CNT_W(CNT_W), .DEST_W(DEST_W)) u_decode (
        .issue_valid     (issue_valid),
        .issue_kind      (issue_kind),
        .issue_nonposted (issue_nonposted),
        .cmpl_valid      (cmpl_valid),
        .cmpl_kind       (cmpl_kind),
        .cmpl_ack_count  (cmpl_ack_count),
        .fixed_inc       (fixed_inc),
        .outst_inc       (outst_inc),
        .outst_dec       (outst_dec)
    );

    for (genvar f = 0; f < NUM_FIXED; f++) begin : g_fixed
        stat_accum #(.CNT_W(CNT_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (fixed_inc[f]),
            .q     (fixed_q[f])
        );
    end

    stat_outstanding_bank #(.CNT_W(CNT_W), .NUM_ID(NUM_ID), .TID_W(TID_W)) u_outst (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (outst_inc),
        .inc_tid   (issue_tid),
        .dec_valid (outst_dec),
        .dec_tid   (cmpl_tid),
        .clr_valid (clr_hit),
        .clr_mask  (clr_mask),
        .q         (outst_q)
    );

    stat_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ID(NUM_ID)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .fixed_q (fixed_q),
        .outst_q (outst_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/txn_status_counters_chk.sv
// Module: txn_status_counters_chk
// Temporal checks on the counter bank, bound into every instance of the top.
// Observes ports and the registered counter state.
module txn_status_counters_chk
    import txn_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DEST_W = 8,
    parameter int NUM_ID = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TID_W  = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             issue_valid,
    input logic [1:0]                       issue_kind,
    input logic                             cmpl_valid,
    input logic [1:0]                       cmpl_kind,
    input logic [TID_W-1:0]                 cmpl_tid,
    input logic [DEST_W-1:0]                cmpl_ack_count,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [NUM_ID-1:0]                clr_mask,
    input logic [ADDR_W-1:0]                rd_addr,
    input logic [DATA_W-1:0]                rd_data,
    input logic [NUM_FIXED-1:0][CNT_W-1:0]  fixed_q,
    input logic [NUM_ID-1:0][CNT_W-1:0]     outst_q
);

    logic clr_now;
    logic no_events;
    assign clr_now   = wr_en && (wr_addr == ADDR_W'(CLEAR_REG_OFFSET));
    assign no_events = !issue_valid && !cmpl_valid;

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (fixed_q == '0 && outst_q == '0));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(CNT_REGION_BASE + 4 * fixed_slot_index(FIX_ACCEPTED)))
        |=> rd_data == DATA_W'($past(fixed_q[FIX_ACCEPTED])));

    assert_accept_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_kind != 2'd3)
        |=> fixed_q[FIX_ACCEPTED] == CNT_W'($past(fixed_q[FIX_ACCEPTED]) + CNT_W'(1)));

    assert_ack_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_kind == 2'd1)
        |=> fixed_q[FIX_WR_ACK] ==
            CNT_W'($past(fixed_q[FIX_WR_ACK]) + CNT_W'($past(cmpl_ack_count))));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_events |=> $stable(fixed_q));

    for (genvar i = 0; i < NUM_ID; i++) begin : g_id
        assert_mask_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_now && clr_mask[i] && no_events) |=> outst_q[i] == '0);

        assert_floor_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl_valid && cmpl_kind != 2'd3 && cmpl_tid == TID_W'(i) &&
             !issue_valid && !clr_now)
            |=> outst_q[i] == (($past(outst_q[i]) == '0) ? '0
                               : CNT_W'($past(outst_q[i]) - CNT_W'(1))));
    end

endmodule

bind txn_status_counters txn_status_counters_chk #(
    .CNT_W(CNT_W), .DEST_W(DEST_W), .NUM_ID(NUM_ID),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .issue_kind     (issue_kind),
    .cmpl_valid     (cmpl_valid),
    .cmpl_kind      (cmpl_kind),
    .cmpl_tid       (cmpl_tid),
    .cmpl_ack_count (cmpl_ack_count),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .clr_mask       (clr_mask),
    .rd_addr        (rd_addr),
    .rd_data        (rd_data),
    .fixed_q        (fixed_q),
    .outst_q        (outst_q)
);

// File: tb/txn_status_counters_bench.sv
// Bench: a behavioural slot model predicts rd_data on every cycle.
// The counter width is reduced to 10 bits so that wrap can be reached.
module txn_status_counters_bench;

    localparam int CNT_W  = 10;
    localparam int DEST_W = 8;
    localparam int NUM_ID = 16;
    localparam longint MODV = longint'(1) << CNT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_kind = 2'd0;
    logic        issue_nonposted = 1'b0;
    logic [3:0]  issue_tid = 4'd0;
    logic        cmpl_valid = 1'b0;
    logic [1:0]  cmpl_kind = 2'd0;
    logic [3:0]  cmpl_tid = 4'd0;
    logic [7:0]  cmpl_ack_count = 8'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = 16'd0;
    logic [31:0] wr_data = 32'd0;
    logic [15:0] rd_addr = 16'd0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    longint m [0:127];

    always #10 clk = ~clk;

    txn_status_counters #(.CNT_W(CNT_W), .DEST_W(DEST_W), .NUM_ID(NUM_ID)) u_txn_status_counters (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_kind(issue_kind),
        .issue_nonposted(issue_nonposted), .issue_tid(issue_tid),
        .cmpl_valid(cmpl_valid), .cmpl_kind(cmpl_kind),
        .cmpl_tid(cmpl_tid), .cmpl_ack_count(cmpl_ack_count),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic longint model_read(input logic [15:0] a);
        if (a >= 16'h200 && a < 16'h400 && a[1:0] == 2'b00) return m[(a - 16'h200) >> 2];
        return 0;
    endfunction

    function automatic void bump(input int idx, input longint amt);
        m[idx] = (m[idx] + amt) % MODV;
    endfunction

    // Apply the inputs of the current cycle to the model
    function automatic void model_step();
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m[i] = 0;
            return;
        end
        if (wr_en && wr_addr == 16'h0060)
            for (int i = 0; i < NUM_ID; i++) if (wr_data[i]) m[16 + i] = 0;
        if (issue_valid) begin
            case (issue_kind)
                2'd0: begin bump(4, 1); bump(5, 1); bump(16 + issue_tid, 1); end
                2'd1: begin
                    bump(4, 1);
                    if (issue_nonposted) begin bump(10, 1); bump(16 + issue_tid, 1); end
                    else bump(11, 1);
                end
                2'd2: begin bump(4, 1); bump(16 + issue_tid, 1); end
                default: ;
            endcase
        end
        if (cmpl_valid && cmpl_kind != 2'd3) begin
            case (cmpl_kind)
                2'd0: bump(2, 1);
                2'd1: bump(1, cmpl_ack_count);
                default: bump(0, 1);
            endcase
            if (m[16 + cmpl_tid] > 0) m[16 + cmpl_tid] = m[16 + cmpl_tid] - 1;
        end
    endfunction

    // One clock: predict, advance, compare at the next falling edge, go idle
    task automatic cyc(input string tag);
        logic [31:0] exp;
        exp = rst_n ? 32'(model_read(rd_addr)) : 32'd0;
        model_step();
        @(negedge clk);
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, rd_addr, rd_data, exp);
        end
        issue_valid = 1'b0;
        cmpl_valid  = 1'b0;
        wr_en       = 1'b0;
    endtask

    task automatic rd_slot(input int idx, input string tag);
        rd_addr = 16'(16'h200 + 4 * idx);
        cyc(tag);
        cyc(tag);
    endtask

    task automatic issue(input int kind, input bit np, input int tid);
        issue_valid = 1'b1; issue_kind = 2'(kind); issue_nonposted = np; issue_tid = 4'(tid);
    endtask

    task automatic cmpl(input int kind, input int tid, input int acks);
        cmpl_valid = 1'b1; cmpl_kind = 2'(kind); cmpl_tid = 4'(tid); cmpl_ack_count = 8'(acks);
    endtask

    task automatic check_fixed(input string tag);
        rd_slot(0, tag); rd_slot(1, tag); rd_slot(2, tag); rd_slot(4, tag);
        rd_slot(5, tag); rd_slot(10, tag); rd_slot(11, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 0;
        @(negedge clk);
        rst_n = 1'b0;
        cyc("R1"); cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        // R1, R2: sweep the whole window after reset
        for (int i = 0; i < 128; i++) begin rd_addr = 16'(16'h200 + 4 * i); cyc("R1"); end
        // R2: addresses outside or misaligned read zero
        rd_addr = 16'h0000; cyc("R2");
        rd_addr = 16'h0060; cyc("R2");
        rd_addr = 16'h0400; cyc("R2");
        rd_addr = 16'h0205; cyc("R2");

        // R3: issue accounting
        issue(0, 0, 2); cyc("R3"); check_fixed("R3");
        issue(1, 1, 2); cyc("R3"); check_fixed("R3");
        issue(1, 0, 2); cyc("R3"); check_fixed("R3");
        issue(2, 0, 2); cyc("R3"); check_fixed("R3");
        rd_slot(18, "R5");

        // R4: completion accounting, unicast, multicast and zero destinations
        cmpl(2, 2, 0);  cyc("R4"); check_fixed("R4");
        cmpl(0, 2, 0);  cyc("R4"); check_fixed("R4");
        cmpl(1, 2, 1);  cyc("R4"); rd_slot(1, "R4");
        cmpl(1, 6, 37); cyc("R4"); rd_slot(1, "R4");
        cmpl(1, 6, 0);  cyc("R4"); rd_slot(1, "R4");

        // R5: outstanding per ID
        issue(0, 0, 3); cyc("R5");
        issue(2, 0, 3); cyc("R5");
        issue(1, 1, 3); cyc("R5");
        issue(1, 0, 3); cyc("R5");
        rd_slot(19, "R5");
        cmpl(0, 3, 0); cyc("R5"); rd_slot(19, "R5");
        issue(0, 0, 3); cmpl(0, 3, 0); cyc("R5"); rd_slot(19, "R5");
        cmpl(2, 5, 0); cyc("R5"); rd_slot(21, "R5");
        cmpl(2, 5, 0); cyc("R5"); rd_slot(21, "R5");

        // R6: mask clear, alone and stacked with same-cycle events
        issue(0, 0, 1); cyc("R6"); issue(0, 0, 1); cyc("R6");
        issue(0, 0, 7); cyc("R6"); issue(2, 0, 4); cyc("R6");
        wr_en = 1'b1; wr_addr = 16'h0060; wr_data = 32'h0000_0082; cyc("R6");
        rd_slot(17, "R6"); rd_slot(23, "R6"); rd_slot(19, "R6"); rd_slot(20, "R6");
        issue(0, 0, 4); cyc("R6");
        wr_en = 1'b1; wr_addr = 16'h0060; wr_data = 32'hFFFF_0010;
        issue(0, 0, 4); cyc("R6"); rd_slot(20, "R6");
        wr_en = 1'b1; wr_addr = 16'h0060; wr_data = 32'h0000_0010;
        cmpl(0, 4, 0); cyc("R6"); rd_slot(20, "R6");

        // R7: wrap of the acknowledgement counter and same-cycle summation
        for (int k = 0; k < 6; k++) begin cmpl(1, 9, 255); cyc("R7"); end
        rd_slot(1, "R7");
        issue(0, 0, 8); cmpl(0, 8, 0); cyc("R7"); check_fixed("R7"); rd_slot(24, "R7");

        // R8: writes outside the clear register and kind 3 events change nothing
        wr_en = 1'b1; wr_addr = 16'h0204; wr_data = 32'hFFFF_FFFF; cyc("R8");
        wr_en = 1'b1; wr_addr = 16'h0244; wr_data = 32'hFFFF_FFFF; cyc("R8");
        wr_en = 1'b1; wr_addr = 16'h0064; wr_data = 32'hFFFF_FFFF; cyc("R8");
        issue(3, 1, 3); cmpl(3, 3, 200); cyc("R8");
        check_fixed("R8"); rd_slot(19, "R8");

        // R7: random mix compared on every clock
        for (int n = 0; n < 3000; n++) begin
            int pick;
            if ($urandom_range(0, 2) != 0) issue(int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 15)));
            if ($urandom_range(0, 2) != 0) cmpl(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 1'b1;
                wr_addr = ($urandom_range(0, 1) == 0) ? 16'h0060 : 16'(16'h200 + 4 * $urandom_range(0, 127));
                wr_data = $urandom;
            end
            pick = int'($urandom_range(0, 9));
            case (pick)
                0: rd_addr = 16'h200; 1: rd_addr = 16'h204; 2: rd_addr = 16'h208;
                3: rd_addr = 16'h210; 4: rd_addr = 16'h214; 5: rd_addr = 16'h228;
                6: rd_addr = 16'h22C;
                default: rd_addr = 16'(16'h240 + 4 * $urandom_range(0, 15));
            endcase
            cyc("R7");
        end

        // R1: reset after activity returns everything to zero
        rst_n = 1'b0; cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) begin rd_addr = 16'(16'h200 + 4 * i); cyc("R1"); end
        rd_addr = 16'h0204; cyc("R1");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule